// File: doc/BRIEF.md
# Host Interrupt Status and MSI Message Encoder

This block sits on the device side of a host link and collects single-cycle event pulses from the rest of the device. Each event has its own bit in a sticky status register. The host clears a bit by writing a 1 to it. A mask register with the same bit layout selects which latched events may raise the level interrupt line. A global enable bit in a control register gates both the interrupt line and message generation.

Every time an event bit goes from clear to set while its mask bit and the global enable are on, the block queues a numeric message code for that event. Codes 0 to 3 are kept for link-layer errors and codes 7 and 8 are reserved, so they never come from this block. Queued codes leave through a valid/ready stream one at a time, lowest code first.

Back-pressure on that stream follows these rules:
- `msi_valid` and `msi_code` stay constant until the cycle in which `msi_ready` is sampled high.
- A code leaves the queue only on that handshake.
- If an event posts a code that is already queued, the two collapse into a single message.

Top module: `hirq_msi_top`

## Requirements
- R1: A pulse on `evt_pulse[i]`, for i in {0,1,2,5,6,7,8,9,10}, sets status bit i. The bit is visible in the status read at offset 0x520 from the cycle after the pulse, and it stays set until it is cleared. After reset the status register is 0.
- R2: Pulses on `evt_pulse[3]` and `evt_pulse[4]` are ignored. Status bits 3, 4 and 11 to 31 always read as 0.
- R3: A write to offset 0x520 clears every status bit whose write-data bit is 1 and leaves every bit whose write-data bit is 0 unchanged.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: The mask register at offset 0x528 has the status bit layout. It resets to 0x7E7 (all nine defined events). Only bits 0, 1, 2 and 5 to 10 are writable; all other bits read as 0.
- R6: The control register at offset 0x500 holds the global enable in bit 7. The bit resets to 0, and all other control bits read as 0.
- R7: `irq` is high exactly when some bit of (status AND mask) is set and the global enable is 1. It follows register changes in the cycle after the write or pulse.
- R8: A status bit i in {0,1,2,5,6,7,8} that goes from 0 to 1 while mask bit i and the global enable are 1 queues message code i+4, which gives codes 4, 5, 6, 9, 10, 11 and 12. Bits 9 and 10, masked bits, and bits that were already set queue nothing. `msi_code` only ever carries one of these seven codes.
- R9: Queued codes are offered one at a time, lowest code first. `msi_valid` rises the cycle after a code is queued and the stream is idle. While `msi_valid` is high and `msi_ready` is low, `msi_code` holds. A handshake removes the code from the queue, and `msi_valid` is then low for one cycle before the next code is offered.
- R10: Register reads are combinational on `reg_addr`, and offsets other than 0x500, 0x520 and 0x528 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt_pulse | input | 11 | Event pulses, one per status bit position |
| irq | output | 1 | Level interrupt line |
| msi_valid | output | 1 | A message code is offered |
| msi_ready | input | 1 | Consumer accepts the offered code |
| msi_code | output | 8 | Message code being offered |

## Verification
The hardest states to reach from the ports are a full queue that drains under stall, and a status clear that collides with a new pulse on the same bit.

The bench builds the first case on purpose:
- It fires seven message-capable events in one cycle while holding `msi_ready` low.
- It then releases one handshake at a time and checks that the codes come out in ascending order, with the one-cycle gap between them.

It also drives a pulse and a clear of the same bit in one cycle. A long seeded random phase then mixes sparse event bursts, writes to all three registers (so the enable and mask flip mid-stream), and a randomly stalling consumer. A cycle model built from the requirements checks every output in that phase.

// File: rtl/hirq_pkg.sv
package hirq_pkg;

  // Number of status bit positions fed by event inputs.
  localparam int EVT_W = 11;

  // Status positions that carry a real event (3 and 4 are reserved).
  localparam logic [EVT_W-1:0] EVT_DEFINED = 11'h7E7;

  // Number of message code slots tracked by the queue (codes 0..12).
  localparam int NCODE = 13;

  // Offset between a message-capable status bit and its message code.
  localparam int CODE_BIAS = 4;

  // True when status bit b produces a message code.
  function automatic bit bit_has_msg(input int b);
    return (b >= 0) && (b <= 8) && (b != 3) && (b != 4);
  endfunction

  // Message code posted by status bit b.
  function automatic int code_of_bit(input int b);
    return b + CODE_BIAS;
  endfunction

  // Mask of status bits that produce a message code.
  function automatic logic [EVT_W-1:0] msg_bits();
    logic [EVT_W-1:0] m;
    m = '0;
    for (int b = 0; b < EVT_W; b++) m[b] = bit_has_msg(b);
    return m;
  endfunction

endpackage

// File: rtl/hirq_regs.sv
module hirq_regs
  import hirq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int EN_BIT = 7,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h500,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h520,
  parameter logic [ADDR_W-1:0] MASK_OFS = 'h528
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [EVT_W-1:0]  evt,
  output logic [DATA_W-1:0] rdata,
  output logic [EVT_W-1:0]  status,
  output logic [EVT_W-1:0]  mask,
  output logic              gen_en,
  output logic [EVT_W-1:0]  newly_set
);

  logic [EVT_W-1:0] evt_ok;
  logic [EVT_W-1:0] clr_bits;
  logic [EVT_W-1:0] status_nxt;
  logic             wr_stat, wr_mask, wr_ctrl;
  logic             unused_wdata;

  assign wr_stat = wr_en && (addr == STAT_OFS);
  assign wr_mask = wr_en && (addr == MASK_OFS);
  assign wr_ctrl = wr_en && (addr == CTRL_OFS);

  assign evt_ok     = evt & EVT_DEFINED;
  assign clr_bits   = wr_stat ? wdata[EVT_W-1:0] : '0;
  assign newly_set  = evt_ok & ~status;
  // A pulse in the same cycle as a clear keeps the bit set.
  assign status_nxt = (status & ~clr_bits) | evt_ok;

  assign unused_wdata = ^wdata[DATA_W-1:EVT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= EVT_DEFINED;
      gen_en <= 1'b0;
    end else begin
      status <= status_nxt;
      if (wr_mask) mask   <= wdata[EVT_W-1:0] & EVT_DEFINED;
      if (wr_ctrl) gen_en <= wdata[EN_BIT];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == STAT_OFS)      rdata = DATA_W'(status);
    else if (addr == MASK_OFS) rdata = DATA_W'(mask);
    else if (addr == CTRL_OFS) rdata = DATA_W'(gen_en) << EN_BIT;
  end

  assert_rsvd_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~EVT_DEFINED) == '0);

  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && evt_ok == '0) |=> status == ($past(status) & ~$past(wdata[EVT_W-1:0])));

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ok != '0) |=> ((status & $past(evt_ok)) == $past(evt_ok)));

  assert_mask_layout_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask & ~EVT_DEFINED) == '0);

endmodule

// File: rtl/hirq_msi_map.sv
module hirq_msi_map
  import hirq_pkg::*;
(
  input  logic [EVT_W-1:0] newly_set,
  input  logic [EVT_W-1:0] mask,
  input  logic             gen_en,
  output logic [NCODE-1:0] post
);

  localparam logic [EVT_W-1:0] MSG_BITS = msg_bits();

  logic unused_map;
  assign unused_map = ^{newly_set & ~MSG_BITS, mask & ~MSG_BITS};

  for (genvar c = 0; c < NCODE; c++) begin : g_code
    if (bit_has_msg(c - CODE_BIAS)) begin : g_live
      assign post[c] = newly_set[c-CODE_BIAS] & mask[c-CODE_BIAS] & gen_en;
    end else begin : g_tie
      assign post[c] = 1'b0;
    end
  end

endmodule

// File: rtl/hirq_msi_queue.sv
module hirq_msi_queue
  import hirq_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCODE-1:0]  post,
  input  logic              msi_ready,
  output logic              msi_valid,
  output logic [CODE_W-1:0] msi_code
);

  localparam int IDX_W = $clog2(NCODE);

  logic [NCODE-1:0] pend;
  logic [NCODE-1:0] pend_nxt;
  logic [NCODE-1:0] ack_mask;
  logic [IDX_W-1:0] low_idx;
  logic [IDX_W-1:0] code_q;
  logic             valid_q;
  logic             fire;

  assign fire     = valid_q && msi_ready;
  assign ack_mask = fire ? (NCODE'(1) << code_q) : '0;
  // A post arriving with the handshake of the same code keeps it queued.
  assign pend_nxt = (pend & ~ack_mask) | post;

  always_comb begin
    low_idx = '0;
    for (int i = NCODE - 1; i >= 0; i--) begin
      if (pend[i]) low_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= '0;
      valid_q <= 1'b0;
      code_q  <= '0;
    end else begin
      pend <= pend_nxt;
      if (fire) begin
        valid_q <= 1'b0;
      end else if (!valid_q && (pend != '0)) begin
        valid_q <= 1'b1;
        code_q  <= low_idx;
      end
    end
  end

  assign msi_valid = valid_q;
  assign msi_code  = CODE_W'(code_q);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && !msi_ready) |=> (msi_valid && $stable(msi_code)));

  assert_offer_queued_R9: assert property (@(posedge clk) disable iff (!rst_n)
    msi_valid |-> ((pend & (NCODE'(1) << code_q)) != '0));

  assert_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && msi_ready) |=> !msi_valid);

endmodule

// File: rtl/hirq_msi_top.sv
module hirq_msi_top
  import hirq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CODE_W = 8,
  parameter int EN_BIT = 7,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h500,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h520,
  parameter logic [ADDR_W-1:0] MASK_OFS = 'h528
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [EVT_W-1:0]  evt_pulse,
  output logic              irq,
  output logic              msi_valid,
  input  logic              msi_ready,
  output logic [CODE_W-1:0] msi_code
);

  logic [EVT_W-1:0] status, mask, newly_set;
  logic             gen_en;
  logic [NCODE-1:0] post;

  hirq_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_BIT(EN_BIT),
    .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .evt(evt_pulse), .rdata(reg_rdata),
    .status(status), .mask(mask), .gen_en(gen_en), .newly_set(newly_set)
  );

  hirq_msi_map u_map (
    .newly_set(newly_set), .mask(mask), .gen_en(gen_en), .post(post)
  );

  hirq_msi_queue #(.CODE_W(CODE_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .post(post), .msi_ready(msi_ready),
    .msi_valid(msi_valid), .msi_code(msi_code)
  );

  assign irq = gen_en && ((status & mask) != '0);

  assert_code_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    msi_valid |-> ((msi_code >= 4 && msi_code <= 6) || (msi_code >= 9 && msi_code <= 12)));

  assert_irq_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (gen_en && (mask != '0)));

endmodule

// File: tb/tb_hirq_msi_top.sv
module tb_hirq_msi_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_CTRL = 12'h500;
  localparam logic [11:0] A_STAT = 12'h520;
  localparam logic [11:0] A_MASK = 12'h528;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr_en = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [10:0] evt_pulse = 0;
  logic        irq;
  logic        msi_valid;
  logic        msi_ready = 0;
  logic [7:0]  msi_code;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  hirq_msi_top dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
    .irq(irq), .msi_valid(msi_valid), .msi_ready(msi_ready), .msi_code(msi_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model built from the requirements.
  logic [10:0] m_stat, m_mask;
  logic        m_en;
  logic [12:0] m_pend;
  logic        m_valid;
  int          m_code;
  logic [10:0] t_ev, t_clr, t_new;
  logic [12:0] t_np;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat = 0; m_mask = 11'h7E7; m_en = 0; m_pend = 0; m_valid = 0; m_code = 0;
    end else begin
      t_ev  = evt_pulse & 11'h7E7;
      t_new = t_ev & ~m_stat;
      t_clr = (reg_wr_en && reg_addr == A_STAT) ? reg_wdata[10:0] : 11'h0;
      t_np  = m_pend;
      if (m_valid && msi_ready) t_np[m_code] = 1'b0;
      for (int b = 0; b <= 8; b++)
        if (b != 3 && b != 4 && t_new[b] && m_mask[b] && m_en) t_np[b+4] = 1'b1;
      if (m_valid && msi_ready) m_valid = 0;
      else if (!m_valid && m_pend != 0) begin
        m_valid = 1;
        for (int c = 12; c >= 0; c--) if (m_pend[c]) m_code = c;
      end
      m_stat = (m_stat & ~t_clr) | t_ev;
      if (reg_wr_en && reg_addr == A_MASK) m_mask = reg_wdata[10:0] & 11'h7E7;
      if (reg_wr_en && reg_addr == A_CTRL) m_en = reg_wdata[7];
      m_pend = t_np;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    if (a == A_STAT) return {21'h0, m_stat};
    if (a == A_MASK) return {21'h0, m_mask};
    if (a == A_CTRL) return {24'h0, m_en, 7'h0};
    return 32'h0;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic [10:0] e, input logic w, input logic [11:0] a,
                     input logic [31:0] d, input logic r, input string req);
    @(negedge clk);
    evt_pulse = e; reg_wr_en = w; reg_addr = a; reg_wdata = d; msi_ready = r;
    #1;
    chk({31'h0, irq}, {31'h0, m_en && ((m_stat & m_mask) != 0)}, "R7");
    chk({31'h0, msi_valid}, {31'h0, m_valid}, "R9");
    if (m_valid) chk({24'h0, msi_code}, m_code, "R8");
    chk(reg_rdata, exp_rd(a), req);
  endtask

  task automatic idle(input int n, input logic [11:0] a, input logic r, input string req);
    for (int i = 0; i < n; i++) cyc(11'h0, 1'b0, a, 32'h0, r, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  int codes[7] = '{4, 5, 6, 9, 10, 11, 12};

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // Reset state
    idle(1, A_MASK, 0, "R5");
    chk(reg_rdata, 32'h7E7, "R5 mask reset");
    idle(1, A_CTRL, 0, "R6");
    chk(reg_rdata, 32'h0, "R6 control reset");
    idle(1, A_STAT, 0, "R1");
    chk(reg_rdata, 32'h0, "R1 status reset");
    chk({31'h0, irq}, 32'h0, "R7 irq reset");
    chk({31'h0, msi_valid}, 32'h0, "R9 valid reset");

    // Enable, burst of all message events with consumer stalled
    cyc(11'h0, 1, A_CTRL, 32'h80, 0, "R6");
    cyc(11'h1E7, 0, A_STAT, 32'h0, 0, "R1");
    idle(2, A_STAT, 0, "R1");
    chk(reg_rdata, 32'h1E7, "R1 burst latched");
    idle(3, A_STAT, 0, "R9");
    for (int k = 0; k < 7; k++) begin
      chk({31'h0, msi_valid}, 32'h1, "R9 offered");
      chk({24'h0, msi_code}, codes[k], "R9 lowest first");
      cyc(11'h0, 0, A_STAT, 32'h0, 1, "R9");
      cyc(11'h0, 0, A_STAT, 32'h0, 0, "R9");
      chk({31'h0, msi_valid}, 32'h0, "R9 gap after handshake");
      cyc(11'h0, 0, A_STAT, 32'h0, 0, "R9");
    end
    chk({31'h0, msi_valid}, 32'h0, "R9 queue drained");

    // Collision of clear and pulse on bit 1
    cyc(11'h002, 1, A_STAT, 32'h2, 0, "R4");
    idle(1, A_STAT, 0, "R4");
    chk(reg_rdata & 32'h2, 32'h2, "R4 set beats clear");
    chk({31'h0, msi_valid}, 32'h0, "R8 already set posts nothing");
    // Write 1 clears, write 0 keeps
    cyc(11'h0, 1, A_STAT, 32'h001, 0, "R3");
    idle(1, A_STAT, 0, "R3");
    chk(reg_rdata, 32'h1E6, "R3 one bit cleared");
    cyc(11'h0, 1, A_STAT, 32'h7FF, 0, "R3");
    idle(1, A_STAT, 0, "R3");
    chk(reg_rdata, 32'h0, "R3 all cleared");

    // Reserved inputs
    cyc(11'h018, 0, A_STAT, 32'h0, 0, "R2");
    idle(3, A_STAT, 0, "R2");
    chk(reg_rdata, 32'h0, "R2 reserved ignored");
    chk({31'h0, irq}, 32'h0, "R2 no irq");
    cyc(11'h0, 1, A_MASK, 32'hFFFFFFFF, 0, "R5");
    idle(1, A_MASK, 0, "R5");
    chk(reg_rdata, 32'h7E7, "R5 writable bits only");
    cyc(11'h0, 1, A_CTRL, 32'hFFFFFFFF, 0, "R6");
    idle(1, A_CTRL, 0, "R6");
    chk(reg_rdata, 32'h80, "R6 only enable bit");

    // Bits 9 and 10 never post a message but raise irq
    cyc(11'h600, 0, A_STAT, 32'h0, 0, "R8");
    idle(4, A_STAT, 0, "R8");
    chk({31'h0, msi_valid}, 32'h0, "R8 no code for 9/10");
    chk({31'h0, irq}, 32'h1, "R7 irq on");
    cyc(11'h0, 1, A_CTRL, 32'h0, 0, "R7");
    idle(1, A_CTRL, 0, "R7");
    chk({31'h0, irq}, 32'h0, "R7 enable gates irq");
    cyc(11'h0, 1, A_STAT, 32'h7FF, 0, "R3");

    // Masked event posts nothing
    cyc(11'h0, 1, A_CTRL, 32'h80, 0, "R6");
    cyc(11'h0, 1, A_MASK, 32'h7E5, 0, "R5");
    cyc(11'h002, 0, A_STAT, 32'h0, 0, "R8");
    idle(4, A_STAT, 0, "R8");
    chk({31'h0, msi_valid}, 32'h0, "R8 masked no code");
    chk({31'h0, irq}, 32'h0, "R7 masked no irq");
    idle(1, 12'h530, 0, "R10");
    chk(reg_rdata, 32'h0, "R10 unmapped offset");

    // Seeded random phase
    for (int n = 0; n < 6000; n++) begin
      logic [10:0] e;
      logic        w;
      logic [11:0] a;
      logic [31:0] d;
      e = ($urandom % 6 == 0) ? 11'($urandom) : 11'h0;
      w = ($urandom % 4 == 0);
      case ($urandom % 5)
        0: a = A_CTRL;
        1, 2: a = A_STAT;
        3: a = A_MASK;
        default: a = 12'h530;
      endcase
      d = $urandom;
      if (a == A_CTRL && ($urandom % 4 != 0)) d[7] = 1'b1;
      cyc(e, w, a, d, ($urandom % 3 != 0), "R10");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule